// File: doc/BRIEF.md
# Bus Data-Float Wait-State Controller

This block works inside a static external-memory bus sequencer. After a read, the memory device needs some cycles to release the shared data bus. This block decides how many idle cycles to add before the next access begins. Each chip select has its own float length (0 to 15 cycles) and a one-bit optimization enable. Each request carries its own chip select, its direction, the hold length of its control strobe and the setup length of its control strobe.

Requests enter on a valid/ready stream. The controller accepts a request only when it is idle, on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while the controller is stalling and during the start cycle. While it is low, the requester must hold its request, and nothing on the request pins is taken.

After a request is accepted, `stall` stays high for the computed number of wait cycles. Then `start` pulses for one cycle, and `start_cs` names the chip select of that access. The hold cycles of the earlier read always count toward the float time. When optimization is enabled for the chip select of that read, the setup cycles of the new access also count toward it.

Top module: `fws_top`

## Requirements
- R1: After reset, `stall` and `start` are low and `req_ready` is high. No earlier read is on record, so the first access gets zero wait cycles.
- R2: A request is taken only on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is low on every cycle where `stall` or `start` is high.
- R3: A read followed by a read on a different chip select waits max(0, F − H − S·opt) cycles. F is the float count of the earlier read's chip select, H is the hold of the earlier read, S is the setup of the new access, and opt is 1 when optimization is on.
- R4: A read followed by a write on a different chip select uses the same wait formula as R3.
- R5: A read followed by a write on the same chip select uses the same wait formula as R3.
- R6: A read followed by a read on the same chip select gets zero wait cycles.
- R7: Any access that follows a write gets zero wait cycles.
- R8: When optimization is off for the earlier read's chip select, S has no effect, and the wait is max(0, F − H). For example, F=6 and H=4 give 2 cycles.
- R9: When optimization is on, S counts toward the float time. For example, F=6, H=4 and S=3 give 0 cycles.
- R10: A float count of zero never produces wait cycles.
- R11: F and opt come from the chip select of the earlier read, not from the chip select of the new access. The float count for chip select i is `cfg_float[4*i+3:4*i]`, and its enable is `cfg_opt[i]`.
- R12: `stall` is high for exactly the computed number of consecutive cycles, starting in the first cycle after acceptance. `start` is high for one cycle: the cycle after `stall` falls, or the first cycle after acceptance when the wait is zero. `start_cs` equals the chip select of the accepted access while `start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_float | input | NUM_CS*4 | Float count for each chip select, 4 bits each |
| cfg_opt | input | NUM_CS | Float optimization enable for each chip select |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_cs | input | CSW | Chip select of the request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_hold | input | TW | Strobe hold length of the request |
| req_setup | input | TW | Strobe setup length of the request |
| stall | output | 1 | High during inserted float wait cycles |
| start | output | 1 | One-cycle pulse marking the start of the accepted access |
| start_cs | output | CSW | Chip select of the access that is starting |

## Verification
The bench builds the controller with its defaults: four chip selects and 4-bit hold and setup fields. With these values, a random stream reaches same and different chip-select pairs in every combination of directions. The random stream also covers hold plus setup both below and above the float count, and the full float range up to the 15-cycle stall. Directed cases cover the 6/4/3 example with optimization on and off, a float count of zero, and a case where the earlier read's chip select has a different float count and enable from the new access's chip select.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int FLOAT_W = 4;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STALL = 2'd1,
    ST_START = 2'd2
  } fws_state_e;

  typedef struct packed {
    logic       valid;
    logic       is_read;
  } fws_hist_t;
endpackage

// File: rtl/fws_cfg_sel.sv
module fws_cfg_sel #(
  parameter int NUM_CS = 4,
  parameter int FW     = 4,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS*FW-1:0] cfg_float,
  input  logic [NUM_CS-1:0]    cfg_opt,
  input  logic [CSW-1:0]       sel,
  output logic [FW-1:0]        float_cnt,
  output logic                 opt_en
);
  logic [FW-1:0] fl_arr [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_split
    assign fl_arr[i] = cfg_float[i*FW +: FW];
  end

  always_comb begin
    float_cnt = '0;
    opt_en    = 1'b0;
    for (int k = 0; k < NUM_CS; k++) begin
      if (sel == CSW'(k)) begin
        float_cnt = fl_arr[k];
        opt_en    = cfg_opt[k];
      end
    end
  end
endmodule

// File: rtl/fws_calc.sv
module fws_calc #(
  parameter int NUM_CS = 4,
  parameter int FW     = 4,
  parameter int TW     = 4,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int SW    = ((FW > TW) ? FW : TW) + 2
) (
  input  logic           prev_valid,
  input  logic           prev_read,
  input  logic [CSW-1:0] prev_cs,
  input  logic [TW-1:0]  prev_hold,
  input  logic [FW-1:0]  float_cnt,
  input  logic           opt_en,
  input  logic           next_read,
  input  logic [CSW-1:0] next_cs,
  input  logic [TW-1:0]  next_setup,
  output logic [FW-1:0]  waits
);
  logic          applies;
  logic [SW-1:0] covered;
  logic [SW-1:0] fl_ext;
  logic [SW-1:0] diff;

  always_comb begin
    applies = prev_valid && prev_read && !(next_read && (next_cs == prev_cs));
    covered = SW'(prev_hold) + (opt_en ? SW'(next_setup) : SW'(0));
    fl_ext  = SW'(float_cnt);
    diff    = fl_ext - covered;
    if (applies && (fl_ext > covered))
      waits = diff[FW-1:0];
    else
      waits = '0;
  end
endmodule

// File: rtl/fws_seq.sv
module fws_seq #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [FW-1:0] waits,
  output logic          stall,
  output logic          start,
  output logic          idle
);
  import fws_pkg::*;

  fws_state_e    st_q;
  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (waits == '0) st_q <= ST_START;
          else begin
            st_q  <= ST_STALL;
            cnt_q <= waits;
          end
        end
        ST_STALL: begin
          if (cnt_q == FW'(1)) st_q <= ST_START;
          cnt_q <= cnt_q - FW'(1);
        end
        ST_START: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign stall = (st_q == ST_STALL);
  assign start = (st_q == ST_START);
  assign idle  = (st_q == ST_IDLE);
endmodule

// File: rtl/fws_top.sv
module fws_top #(
  parameter int NUM_CS = 4,
  parameter int TW     = 4,
  localparam int FW    = fws_pkg::FLOAT_W,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CS*FW-1:0] cfg_float,
  input  logic [NUM_CS-1:0]    cfg_opt,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CSW-1:0]       req_cs,
  input  logic                 req_read,
  input  logic [TW-1:0]        req_hold,
  input  logic [TW-1:0]        req_setup,
  output logic                 stall,
  output logic                 start,
  output logic [CSW-1:0]       start_cs
);
  import fws_pkg::*;

  fws_hist_t      hist_q;
  logic [CSW-1:0] prev_cs_q;
  logic [TW-1:0]  prev_hold_q;
  logic [CSW-1:0] cur_cs_q;
  logic [FW-1:0]  sel_float;
  logic           sel_opt;
  logic [FW-1:0]  waits;
  logic           idle;
  logic           accept;

  assign req_ready = idle;
  assign accept    = req_valid && idle;

  fws_cfg_sel #(.NUM_CS(NUM_CS), .FW(FW)) u_sel (
    .cfg_float (cfg_float),
    .cfg_opt   (cfg_opt),
    .sel       (prev_cs_q),
    .float_cnt (sel_float),
    .opt_en    (sel_opt)
  );

  fws_calc #(.NUM_CS(NUM_CS), .FW(FW), .TW(TW)) u_calc (
    .prev_valid (hist_q.valid),
    .prev_read  (hist_q.is_read),
    .prev_cs    (prev_cs_q),
    .prev_hold  (prev_hold_q),
    .float_cnt  (sel_float),
    .opt_en     (sel_opt),
    .next_read  (req_read),
    .next_cs    (req_cs),
    .next_setup (req_setup),
    .waits      (waits)
  );

  fws_seq #(.FW(FW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .waits  (waits),
    .stall  (stall),
    .start  (start),
    .idle   (idle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q      <= '0;
      prev_cs_q   <= '0;
      prev_hold_q <= '0;
      cur_cs_q    <= '0;
    end else if (accept) begin
      hist_q.valid   <= 1'b1;
      hist_q.is_read <= req_read;
      prev_cs_q      <= req_cs;
      prev_hold_q    <= req_hold;
      cur_cs_q       <= req_cs;
    end
  end

  assign start_cs = cur_cs_q;
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int FW = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic stall,
  input logic start
);
  logic [FW:0] run_q;
  logic        acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      acc_q <= 1'b0;
    end else begin
      run_q <= stall ? run_q + 1'b1 : '0;
      acc_q <= req_valid && req_ready;
    end
  end

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (stall || start) |-> !req_ready); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) start |=> !start); // R12
  AST_START_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n) (acc_q && $fell(stall)) || ($fell(stall) && !acc_q) |-> start); // R12
  AST_ACCEPT_REACTS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> (stall || start)); // R12
  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) run_q <= (FW+1)'((1 << FW) - 1)); // R10
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(stall && start)); // R12
endmodule

bind fws_top fws_checker #(.FW(fws_pkg::FLOAT_W)) u_fws_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .stall     (stall),
  .start     (start)
);

// File: tb/fws_top_tb.sv
module fws_top_tb;
  localparam int NCS = 4;
  localparam int TW  = 4;
  localparam int CSW = 2;

  logic           clk = 0;
  logic           rst_n = 0;
  logic [NCS*4-1:0] cfg_float = '0;
  logic [NCS-1:0] cfg_opt = '0;
  logic           req_valid = 0;
  logic           req_ready;
  logic [CSW-1:0] req_cs = '0;
  logic           req_read = 0;
  logic [TW-1:0]  req_hold = '0;
  logic [TW-1:0]  req_setup = '0;
  logic           stall, start;
  logic [CSW-1:0] start_cs;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  bit             m_valid = 0;
  bit             m_read = 0;
  int             m_cs = 0;
  int             m_hold = 0;

  always #5 clk = ~clk;

  fws_top #(.NUM_CS(NCS), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_float(cfg_float), .cfg_opt(cfg_opt),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .req_read(req_read), .req_hold(req_hold), .req_setup(req_setup),
    .stall(stall), .start(start), .start_cs(start_cs)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_waits(input bit rd, input int cs, input int setup);
    int f, c;
    bit o;
    if (!m_valid || !m_read) return 0;
    if (rd && cs == m_cs) return 0;
    f = int'(cfg_float[m_cs*4 +: 4]);
    o = cfg_opt[m_cs];
    c = m_hold + (o ? setup : 0);
    return (f > c) ? f - c : 0;
  endfunction

  task automatic access(input string tag, input bit rd, input int cs,
                        input int hold, input int setup);
    int ew, n;
    ew = exp_waits(rd, cs, setup);
    @(negedge clk);
    check({tag, " R2 ready idle"}, int'(req_ready), 1);
    req_valid = 1; req_read = rd; req_cs = CSW'(cs);
    req_hold = TW'(hold); req_setup = TW'(setup);
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (stall && n < 40) begin
      if (req_ready) check({tag, " R2 ready during stall"}, 1, 0);
      n++;
      @(negedge clk);
    end
    check({tag, " R12 stall length"}, n, ew);
    check({tag, " R12 start pulse"}, int'(start), 1);
    check({tag, " R12 start_cs"}, int'(start_cs), cs);
    m_valid = 1; m_read = rd; m_cs = cs; m_hold = hold;
  endtask

  task automatic set_cfg(input int cs, input int f, input bit o);
    cfg_float[cs*4 +: 4] = 4'(f);
    cfg_opt[cs] = o;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1 stall after reset", int'(stall), 0);
    check("R1 start after reset", int'(start), 0);
    check("R1 ready after reset", int'(req_ready), 1);
    set_cfg(0, 6, 1); set_cfg(1, 6, 0); set_cfg(2, 0, 1); set_cfg(3, 15, 0);
    access("R1 first access", 0, 0, 4, 3);
    // R9 example with optimization on: 6-4-3 -> 0
    access("R9 rd cs0", 1, 0, 4, 0);
    access("R9 R5 wr cs0", 0, 0, 2, 3);
    // R7 after a write nothing waits
    access("R7 rd cs1", 1, 1, 4, 0);
    // R8 example with optimization off: 6-4 -> 2, setup ignored
    access("R8 R4 wr cs0", 0, 0, 1, 3);
    // R6 read-read same cs
    access("R6 rd cs3", 1, 3, 0, 0);
    access("R6 rd cs3 again", 1, 3, 0, 0);
    // R3 read-read other cs, full 15 stall (float from cs3)
    access("R3 R11 rd cs2", 1, 2, 0, 0);
    // R10 float zero on cs2
    access("R10 wr cs3", 0, 3, 0, 0);
    // R11: earlier read on cs1 (opt off), new access on cs0 (opt on)
    access("R11 rd cs1", 1, 1, 1, 0);
    access("R11 rd cs0", 1, 0, 0, 5);
    for (int i = 0; i < 300; i++) begin
      if (i % 25 == 0)
        for (int c = 0; c < NCS; c++) set_cfg(c, int'($urandom_range(15)), 1'($urandom_range(1)));
      access("R3 R4 R5 random", 1'($urandom_range(1)), int'($urandom_range(NCS-1)),
             int'($urandom_range(7)), int'($urandom_range(7)));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule